// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block lets a system bus read a serial NOR flash as if it were memory. Each read request on the bus side becomes one complete flash read transaction. The engine lowers chip select, shifts out a read opcode and an address on a single data line, and clocks a programmable number of idle (dummy) cycles. It then collects one bus word of data on one, two or four data lines, returns the word and raises chip select again. The bus side is held waiting, with no acknowledge, until every byte of the word has arrived.

The flash pins are shared with a separate command-driven engine. A select input, held by the register that owns it, decides which engine drives the clock, chip select and data lanes. A 32-bit setup word supplies the transaction shape: opcode, address length, dummy length and lane mode. When the select is off, or the setup word is all zero, memory-mapped reads are refused with an error acknowledge.

Top module: `sfmm_read_engine`

## Requirements
- R1: With `map_enable` = 0 the four lane outputs, lane enables, serial clock and chip select on the pins follow the `cmd_*` inputs. With `map_enable` = 1 they come from this engine, which idles with chip select high and serial clock low whatever the `cmd_*` inputs carry.
- R2: If `map_enable` is 0 or `setup_word` is all zero, a read request is answered on the next cycle with `rd_ack` = 1, `rd_err` = 1 and `rd_data` = 0, and chip select is never lowered.
- R3: `setup_word` fields: [7:0] read opcode; [9:8] address byte count (0 to 3, and 3 sends a 24-bit address); [11:10] dummy byte count; [28:24] extra dummy bit count; [13:12] lane mode. Bits [23:16] hold a write opcode that has no effect on reads. With n address bytes the low 8·n bits of `rd_addr` are sent.
- R4: The opcode and then the address go out MSB first on lane 0, which is the only enabled lane during that phase. Mode 0 clocking applies: the serial clock idles low, outputs change after a falling edge and inputs are sampled on a rising edge.
- R5: The dummy phase lasts 8·(dummy bytes) + (dummy bits) serial clock cycles, with no lane enabled. No lane is enabled during the data phase either.
- R6: Lane mode 0 receives one bit per cycle on lane 1. Mode 1 receives two bits per cycle on lanes 1 and 0, with lane 1 carrying the earlier bit. Mode 3 receives four bits per cycle on lanes 3 to 0, with lane 3 carrying the earliest bit. Mode 2 behaves as mode 0. Each byte arrives MSB first.
- R7: Received bytes are packed little-endian: the byte at the request address sits in `rd_data[7:0]` and the following bytes sit in ascending byte lanes.
- R8: `rd_ack` is a single-cycle pulse. It is given only after the last data bit is sampled, and chip select is already high in the acknowledge cycle.
- R9: The serial clock half period is `HALF_DIV` core cycles. A request presented at one clock edge is acknowledged exactly 2·HALF_DIV·(8 + 8·addr bytes + dummy cycles + 8·WORD_BYTES/lanes) cycles later.
- R10: During and straight after reset, chip select is high, the serial clock is low, no lane is enabled and `rd_ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| map_enable | input | 1 | Pin ownership select: 1 gives the pins to this engine |
| setup_word | input | 32 | Transaction shape for memory-mapped reads |
| rd_req | input | 1 | Bus read request, held until acknowledged |
| rd_addr | input | 24 | Byte address of the read |
| rd_ack | output | 1 | One-cycle acknowledge of the read |
| rd_err | output | 1 | Read refused (engine disabled) |
| rd_data | output | 32 | Read word, valid with `rd_ack` |
| cmd_sclk | input | 1 | Serial clock from the command engine |
| cmd_cs_n | input | 1 | Chip select from the command engine |
| cmd_io_o | input | 4 | Lane output values from the command engine |
| cmd_io_oe | input | 4 | Lane output enables from the command engine |
| spi_sclk | output | 1 | Serial clock pin |
| spi_cs_n | output | 1 | Chip select pin, active low |
| spi_io_o | output | 4 | Lane output values |
| spi_io_oe | output | 4 | Lane output enables |
| spi_io_i | input | 4 | Lane input values from the pads |

## Verification
The checker watches every cycle for the following: the acknowledge is one cycle long, refused reads return zero, the upper three lanes are never driven by this engine, the serial clock stays low while chip select is high, and chip select is high whenever a word is handed back. The bench supplies what only whole transactions can show. A flash model in the bench decodes the opcode and address it receives and answers on the lane pattern the setup word selects. This checks bit order, lane order, byte packing and the dummy length. The exact acknowledge latency exposes any miscounted phase, and repeated reads that differ only in the write opcode show that field is ignored.

// File: rtl/sfmm_pkg.sv
package sfmm_pkg;

    localparam int NUM_IO     = 4;
    localparam int ADDR_BYTES = 3;
    localparam int ADDR_BITS  = ADDR_BYTES * 8;

    typedef enum logic [1:0] {
        LANE_X1  = 2'd0,
        LANE_X2  = 2'd1,
        LANE_ALT = 2'd2,
        LANE_X4  = 2'd3
    } lane_mode_e;

    // Full layout of the setup word.
    typedef struct packed {
        logic [2:0]  spare_hi;
        logic [4:0]  dummy_bits;
        logic [7:0]  wr_op;
        logic [1:0]  spare_mid;
        lane_mode_e  lanes;
        logic [1:0]  dummy_bytes;
        logic [1:0]  addr_bytes;
        logic [7:0]  rd_op;
    } setup_t;

    // Only what a read transaction needs.
    typedef struct packed {
        logic [7:0]  op;
        logic [1:0]  na;
        logic [5:0]  ndum;
        lane_mode_e  mode;
    } rd_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_DUMMY,
        ST_DATA,
        ST_DONE
    } seq_st_e;

    function automatic rd_cfg_t decode_setup(input logic [31:0] w);
        setup_t  s;
        rd_cfg_t c;
        s      = setup_t'(w);
        c.op   = s.rd_op;
        c.na   = s.addr_bytes;
        c.ndum = {1'b0, s.dummy_bytes, 3'b000} + {1'b0, s.dummy_bits};
        c.mode = s.lanes;
        return c;
    endfunction

    function automatic int lane_count(input lane_mode_e m);
        case (m)
            LANE_X2: return 2;
            LANE_X4: return 4;
            default: return 1;
        endcase
    endfunction

    // Left-align the used address bytes so they follow the opcode directly.
    function automatic logic [ADDR_BITS-1:0] align_addr(input logic [ADDR_BITS-1:0] a,
                                                        input logic [1:0] na);
        return a << (8 * (ADDR_BYTES - int'(na)));
    endfunction

endpackage

// File: rtl/sfmm_tick.sv
module sfmm_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt == W'(HALF_DIV - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == W'(HALF_DIV - 1));
endmodule

// File: rtl/sfmm_seq.sv
module sfmm_seq
    import sfmm_pkg::*;
#(
    parameter int WORD_BYTES = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      tick,
    input  rd_cfg_t                   cfg,
    input  logic [ADDR_BITS-1:0]      addr,
    input  logic [NUM_IO-1:0]         io_i,
    output logic                      run,
    output logic                      idle,
    output logic                      done,
    output logic                      cs_n,
    output logic                      sclk,
    output logic [NUM_IO-1:0]         io_o,
    output logic [NUM_IO-1:0]         io_oe,
    output logic [WORD_BYTES*8-1:0]   rx
);
    localparam int WORD_BITS = WORD_BYTES * 8;
    localparam int MAX_CYC   = (WORD_BITS > 64) ? WORD_BITS : 64;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);
    localparam int SH_W      = 8 + ADDR_BITS;

    seq_st_e            st;
    logic [CNT_W-1:0]   left;
    logic [SH_W-1:0]    sh;
    logic [5:0]         ndum;
    lane_mode_e         mode;
    logic               last;

    function automatic logic [CNT_W-1:0] data_len(input lane_mode_e m);
        return CNT_W'(WORD_BITS / lane_count(m));
    endfunction

    assign last = (left == CNT_W'(1));
    assign run  = (st == ST_SEND) || (st == ST_DUMMY) || (st == ST_DATA);
    assign idle = (st == ST_IDLE);
    assign done = (st == ST_DONE);

    assign io_o  = {{(NUM_IO-1){1'b0}}, (st == ST_SEND) & sh[SH_W-1]};
    assign io_oe = {{(NUM_IO-1){1'b0}}, (st == ST_SEND)};

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cs_n <= 1'b1;
            sclk <= 1'b0;
            left <= '0;
            sh   <= '0;
            ndum <= '0;
            mode <= LANE_X1;
            rx   <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        sh   <= {cfg.op, align_addr(addr, cfg.na)};
                        left <= CNT_W'(8 + 8 * int'(cfg.na));
                        ndum <= cfg.ndum;
                        mode <= cfg.mode;
                        cs_n <= 1'b0;
                        st   <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (tick) begin
                        sclk <= ~sclk;
                        if (sclk) begin
                            sh <= sh << 1;
                            if (last) begin
                                if (ndum != '0) begin
                                    left <= CNT_W'(ndum);
                                    st   <= ST_DUMMY;
                                end else begin
                                    left <= data_len(mode);
                                    st   <= ST_DATA;
                                end
                            end else begin
                                left <= left - 1'b1;
                            end
                        end
                    end
                end
                ST_DUMMY: begin
                    if (tick) begin
                        sclk <= ~sclk;
                        if (sclk) begin
                            if (last) begin
                                left <= data_len(mode);
                                st   <= ST_DATA;
                            end else begin
                                left <= left - 1'b1;
                            end
                        end
                    end
                end
                ST_DATA: begin
                    if (tick) begin
                        sclk <= ~sclk;
                        if (!sclk) begin
                            case (mode)
                                LANE_X2: rx <= {rx[WORD_BITS-3:0], io_i[1], io_i[0]};
                                LANE_X4: rx <= {rx[WORD_BITS-5:0], io_i[3:0]};
                                default: rx <= {rx[WORD_BITS-2:0], io_i[1]};
                            endcase
                        end else if (last) begin
                            cs_n <= 1'b1;
                            st   <= ST_DONE;
                        end else begin
                            left <= left - 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sfmm_pinmux.sv
module sfmm_pinmux
    import sfmm_pkg::*;
(
    input  logic              sel_mm,
    input  logic              eng_sclk,
    input  logic              eng_cs_n,
    input  logic [NUM_IO-1:0] eng_io_o,
    input  logic [NUM_IO-1:0] eng_io_oe,
    input  logic              cmd_sclk,
    input  logic              cmd_cs_n,
    input  logic [NUM_IO-1:0] cmd_io_o,
    input  logic [NUM_IO-1:0] cmd_io_oe,
    output logic              pin_sclk,
    output logic              pin_cs_n,
    output logic [NUM_IO-1:0] pin_io_o,
    output logic [NUM_IO-1:0] pin_io_oe
);
    assign pin_sclk = sel_mm ? eng_sclk : cmd_sclk;
    assign pin_cs_n = sel_mm ? eng_cs_n : cmd_cs_n;

    for (genvar i = 0; i < NUM_IO; i++) begin : g_lane
        assign pin_io_o[i]  = sel_mm ? eng_io_o[i]  : cmd_io_o[i];
        assign pin_io_oe[i] = sel_mm ? eng_io_oe[i] : cmd_io_oe[i];
    end
endmodule

// File: rtl/sfmm_read_engine.sv
module sfmm_read_engine
    import sfmm_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    parameter int HALF_DIV   = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    map_enable,
    input  logic [31:0]             setup_word,
    input  logic                    rd_req,
    input  logic [ADDR_BITS-1:0]    rd_addr,
    output logic                    rd_ack,
    output logic                    rd_err,
    output logic [WORD_BYTES*8-1:0] rd_data,
    input  logic                    cmd_sclk,
    input  logic                    cmd_cs_n,
    input  logic [NUM_IO-1:0]       cmd_io_o,
    input  logic [NUM_IO-1:0]       cmd_io_oe,
    output logic                    spi_sclk,
    output logic                    spi_cs_n,
    output logic [NUM_IO-1:0]       spi_io_o,
    output logic [NUM_IO-1:0]       spi_io_oe,
    input  logic [NUM_IO-1:0]       spi_io_i
);
    localparam int WORD_BITS = WORD_BYTES * 8;

    rd_cfg_t                cfg;
    logic                   enabled;
    logic                   start;
    logic                   err_q;
    logic                   tick;
    logic                   run;
    logic                   idle;
    logic                   done;
    logic                   eng_cs_n;
    logic                   eng_sclk;
    logic [NUM_IO-1:0]      eng_io_o;
    logic [NUM_IO-1:0]      eng_io_oe;
    logic [WORD_BITS-1:0]   rx;
    logic [WORD_BITS-1:0]   packed_word;

    assign cfg     = decode_setup(setup_word);
    assign enabled = map_enable && (setup_word != '0);
    assign start   = rd_req && enabled && idle && !err_q;

    always_ff @(posedge clk) begin
        if (rst)
            err_q <= 1'b0;
        else
            err_q <= rd_req && !enabled && idle && !err_q;
    end

    sfmm_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    sfmm_seq #(.WORD_BYTES(WORD_BYTES)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .tick  (tick),
        .cfg   (cfg),
        .addr  (rd_addr),
        .io_i  (spi_io_i),
        .run   (run),
        .idle  (idle),
        .done  (done),
        .cs_n  (eng_cs_n),
        .sclk  (eng_sclk),
        .io_o  (eng_io_o),
        .io_oe (eng_io_oe),
        .rx    (rx)
    );

    // First byte received lands in the lowest byte lane.
    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_pack
        assign packed_word[8*b +: 8] = rx[WORD_BITS-8-8*b +: 8];
    end

    assign rd_ack  = done | err_q;
    assign rd_err  = err_q;
    assign rd_data = done ? packed_word : '0;

    sfmm_pinmux u_mux (
        .sel_mm    (map_enable),
        .eng_sclk  (eng_sclk),
        .eng_cs_n  (eng_cs_n),
        .eng_io_o  (eng_io_o),
        .eng_io_oe (eng_io_oe),
        .cmd_sclk  (cmd_sclk),
        .cmd_cs_n  (cmd_cs_n),
        .cmd_io_o  (cmd_io_o),
        .cmd_io_oe (cmd_io_oe),
        .pin_sclk  (spi_sclk),
        .pin_cs_n  (spi_cs_n),
        .pin_io_o  (spi_io_o),
        .pin_io_oe (spi_io_oe)
    );
endmodule

// File: rtl/sfmm_read_engine_chk.sv
module sfmm_read_engine_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              map_enable,
    input logic              rd_ack,
    input logic              rd_err,
    input logic [DATA_W-1:0] rd_data,
    input logic              spi_sclk,
    input logic              spi_cs_n,
    input logic [3:0]        spi_io_oe,
    input logic              eng_cs_n,
    input logic              eng_sclk
);
    p_ack_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        rd_ack |=> !rd_ack);

    p_ack_cs_high_r8: assert property (@(posedge clk) disable iff (rst)
        (map_enable && rd_ack && !rd_err) |-> spi_cs_n);

    p_err_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> (rd_ack && (rd_data == '0)));

    p_upper_lanes_r4: assert property (@(posedge clk) disable iff (rst)
        map_enable |-> (spi_io_oe[3:1] == 3'b000));

    p_sclk_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (map_enable && spi_cs_n) |-> !spi_sclk);

    p_after_reset_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (eng_cs_n && !eng_sclk && !rd_ack));
endmodule

bind sfmm_read_engine sfmm_read_engine_chk #(.DATA_W(WORD_BYTES * 8)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .map_enable (map_enable),
    .rd_ack     (rd_ack),
    .rd_err     (rd_err),
    .rd_data    (rd_data),
    .spi_sclk   (spi_sclk),
    .spi_cs_n   (spi_cs_n),
    .spi_io_oe  (spi_io_oe),
    .eng_cs_n   (eng_cs_n),
    .eng_sclk   (eng_sclk)
);

// File: tb/sfmm_read_engine_test.sv
module sfmm_read_engine_test;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        map_enable;
    logic [31:0] setup_word;
    logic        rd_req;
    logic [23:0] rd_addr;
    logic        rd_ack;
    logic        rd_err;
    logic [31:0] rd_data;
    logic        cmd_sclk;
    logic        cmd_cs_n;
    logic [3:0]  cmd_io_o;
    logic [3:0]  cmd_io_oe;
    logic        spi_sclk;
    logic        spi_cs_n;
    logic [3:0]  spi_io_o;
    logic [3:0]  spi_io_oe;
    logic [3:0]  spi_io_i = 4'h0;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    sfmm_read_engine #(.WORD_BYTES(4), .HALF_DIV(HALF)) uut (
        .clk(clk), .rst(rst), .map_enable(map_enable), .setup_word(setup_word),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_err(rd_err),
        .rd_data(rd_data), .cmd_sclk(cmd_sclk), .cmd_cs_n(cmd_cs_n),
        .cmd_io_o(cmd_io_o), .cmd_io_oe(cmd_io_oe), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_io_o(spi_io_o), .spi_io_oe(spi_io_oe),
        .spi_io_i(spi_io_i)
    );

    // ---------------- bench reference functions ----------------
    function automatic logic [7:0] fmem(input logic [23:0] a);
        logic [23:0] t;
        t = (a * 24'd157) ^ (a >> 7);
        return t[7:0] ^ 8'h3C;
    endfunction

    function automatic int b_na();
        return int'(setup_word[9:8]);
    endfunction
    function automatic int b_nd();
        return 8 * int'(setup_word[11:10]) + int'(setup_word[28:24]);
    endfunction
    function automatic int b_lanes();
        case (setup_word[13:12])
            2'd1:    return 2;
            2'd3:    return 4;
            default: return 1;
        endcase
    endfunction
    function automatic int hdr_n();
        return 8 + 8 * b_na();
    endfunction
    function automatic logic [23:0] addr_mask(input int na);
        return (na == 0) ? 24'h0 : 24'(({24'h0, 24'hFFFFFF} >> (24 - 8 * na)));
    endfunction
    function automatic logic [31:0] mk_setup(input logic [7:0] op, input int na, input int dby,
                                             input int mode, input logic [7:0] wop, input int dbits);
        logic [31:0] w;
        w = '0;
        w[7:0]   = op;
        w[9:8]   = 2'(na);
        w[11:10] = 2'(dby);
        w[13:12] = 2'(mode);
        w[23:16] = wop;
        w[28:24] = 5'(dbits);
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    logic        prev_sclk = 1'b0;
    int          fl_cyc = 0;
    logic [31:0] fl_hdr = '0;
    logic [7:0]  cap_op = '0;
    logic [23:0] cap_addr = '0;
    int          oe_bad_hdr = 0;
    int          oe_bad_tail = 0;
    int          cs_low_edges = 0;

    always @(negedge spi_cs_n) cs_low_edges++;

    always @(posedge spi_sclk or negedge spi_sclk or negedge spi_cs_n) begin
        if (map_enable && !spi_cs_n) begin
            if (spi_sclk && !prev_sclk) begin
                if (fl_cyc < hdr_n()) begin
                    if (spi_io_oe !== 4'b0001) oe_bad_hdr++;
                    fl_hdr = {fl_hdr[30:0], spi_io_o[0]};
                end else if (spi_io_oe !== 4'b0000) begin
                    oe_bad_tail++;
                end
                fl_cyc++;
                if (fl_cyc == hdr_n()) begin
                    cap_op   = 8'(fl_hdr >> (8 * b_na()));
                    cap_addr = fl_hdr[23:0] & addr_mask(b_na());
                end
            end else if (!spi_sclk && prev_sclk) begin
                int k;
                k = fl_cyc - hdr_n() - b_nd();
                spi_io_i = 4'h0;
                if (k >= 0 && k < 32 / b_lanes()) begin
                    int g;
                    int b;
                    logic [7:0] by;
                    g  = k * b_lanes();
                    b  = 7 - (g % 8);
                    by = fmem(cap_addr + 24'(g / 8));
                    if (b_lanes() == 1)
                        spi_io_i[1] = by[b];
                    else
                        for (int l = 0; l < b_lanes(); l++)
                            spi_io_i[b_lanes() - 1 - l] = by[b - l];
                end
            end else begin
                fl_cyc = 0;
                fl_hdr = '0;
            end
        end
        prev_sclk = spi_sclk;
    end

    // ---------------- bus read ----------------
    task automatic do_read(input logic [23:0] a, output logic [31:0] d, output logic e,
                           output int cyc, output logic cs_at_ack);
        @(negedge clk);
        rd_req  = 1'b1;
        rd_addr = a;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!rd_ack && cyc < 20000);
        d = rd_data;
        e = rd_err;
        cs_at_ack = spi_cs_n;
        rd_req = 1'b0;
    endtask

    // Full transaction with every result compared to the reference.
    task automatic mm_read(input logic [23:0] a, output logic [31:0] d, output int cyc);
        logic        e;
        logic        csa;
        logic [31:0] exp;
        logic [23:0] ae;
        int          n_cyc;
        ae = a & addr_mask(b_na());
        for (int i = 0; i < 4; i++) exp[8*i +: 8] = fmem(ae + 24'(i));
        n_cyc = hdr_n() + b_nd() + 32 / b_lanes();
        do_read(a, d, e, cyc, csa);
        check(rd_ack === 1'b1 && e === 1'b0, "R8 ack without error", {31'b0, e}, 32'h0);
        check(d === exp, "R6 R7 read data lanes/packing", d, exp);
        check(cyc == 2 * HALF * n_cyc + 1, "R9 R5 acknowledge latency", 32'(cyc), 32'(2 * HALF * n_cyc + 1));
        check(csa === 1'b1, "R8 chip select high at ack", {31'b0, csa}, 32'h1);
        check(cap_op === setup_word[7:0], "R4 opcode on lane 0", {24'b0, cap_op}, {24'b0, setup_word[7:0]});
        check(cap_addr === ae, "R3 R4 address bytes sent", {8'b0, cap_addr}, {8'b0, ae});
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] d;
        logic [31:0] d2;
        logic        e;
        logic        csa;
        int          cyc;
        int          cyc2;
        int          edges0;

        void'($urandom(32'd20240611));
        rst = 1'b1;
        map_enable = 1'b1;
        setup_word = '0;
        rd_req = 1'b0;
        rd_addr = '0;
        cmd_sclk = 1'b1;
        cmd_cs_n = 1'b0;
        cmd_io_o = 4'hF;
        cmd_io_oe = 4'hF;

        // R10: reset state
        repeat (4) @(negedge clk);
        check(spi_cs_n === 1'b1 && spi_sclk === 1'b0 && spi_io_oe === 4'h0 && rd_ack === 1'b0,
              "R10 outputs during reset", {26'b0, spi_cs_n, spi_sclk, spi_io_oe}, 32'h20);
        rst = 1'b0;
        @(negedge clk);
        check(spi_cs_n === 1'b1 && spi_sclk === 1'b0 && spi_io_oe === 4'h0 && rd_ack === 1'b0,
              "R10 outputs after reset", {26'b0, spi_cs_n, spi_sclk, spi_io_oe}, 32'h20);

        // R1: engine owns idle pins regardless of command-side values
        check(spi_cs_n === 1'b1 && spi_sclk === 1'b0 && spi_io_o === 4'h0,
              "R1 engine idle pins", {26'b0, spi_cs_n, spi_sclk, spi_io_o}, 32'h20);

        // R1: pass-through of the command engine
        map_enable = 1'b0;
        for (int i = 0; i < 4; i++) begin
            logic [9:0] r;
            r = 10'($urandom);
            cmd_sclk = r[0]; cmd_cs_n = r[1]; cmd_io_o = r[5:2]; cmd_io_oe = r[9:6];
            @(negedge clk);
            check({spi_io_oe, spi_io_o, spi_cs_n, spi_sclk} === r, "R1 command pins pass through",
                  {22'b0, spi_io_oe, spi_io_o, spi_cs_n, spi_sclk}, {22'b0, r});
        end

        // R2: switch off -> refused
        cmd_cs_n = 1'b1; cmd_sclk = 1'b0; cmd_io_oe = 4'h0;
        setup_word = mk_setup(8'h03, 3, 0, 0, 8'h12, 0);
        edges0 = cs_low_edges;
        do_read(24'h001234, d, e, cyc, csa);
        check(e === 1'b1 && d === 32'h0 && cyc == 1, "R2 refused with switch off",
              {d[30:0], e}, 32'h1);
        // R2: all-zero setup -> refused, no chip select
        map_enable = 1'b1;
        setup_word = '0;
        do_read(24'h004321, d, e, cyc, csa);
        check(e === 1'b1 && d === 32'h0 && cyc == 1, "R2 refused with zero setup",
              {d[30:0], e}, 32'h1);
        repeat (3) @(negedge clk);
        check(cs_low_edges == edges0, "R2 chip select never lowered", 32'(cs_low_edges), 32'(edges0));

        // Directed transactions
        cmd_cs_n = 1'b0; cmd_sclk = 1'b1; cmd_io_oe = 4'hF;
        setup_word = mk_setup(8'h03, 3, 0, 0, 8'h12, 0);          // R6 single lane
        mm_read(24'h000100, d, cyc);
        setup_word = mk_setup(8'h6B, 3, 1, 1, 8'h12, 0);          // R6 dual lane
        mm_read(24'hABCDEF, d, cyc);
        setup_word = mk_setup(8'h6C, 3, 1, 3, 8'h12, 0);          // R6 quad lane
        mm_read(24'h7FFFFE, d, cyc);
        setup_word = mk_setup(8'h3B, 2, 0, 2, 8'h00, 0);          // R6 mode 2 as single
        mm_read(24'h00F00D, d, cyc);
        setup_word = mk_setup(8'hA5, 0, 0, 3, 8'h00, 0);          // R3 no address bytes
        mm_read(24'h123456, d, cyc);
        setup_word = mk_setup(8'h0B, 1, 0, 1, 8'h00, 5);          // R5 dummy bits only
        mm_read(24'h0000C3, d, cyc);
        setup_word = mk_setup(8'hEB, 3, 3, 3, 8'h00, 31);         // R5 longest dummy
        mm_read(24'hFFFFFC, d, cyc);

        // R3: write opcode field has no effect on a read
        setup_word = mk_setup(8'h6B, 3, 1, 1, 8'h12, 0);
        mm_read(24'h345678, d, cyc);
        setup_word = mk_setup(8'h6B, 3, 1, 1, 8'hED, 0);
        mm_read(24'h345678, d2, cyc2);
        check(d2 === d && cyc2 == cyc, "R3 write opcode ignored", d2, d);

        // Constrained random transactions
        for (int n = 0; n < 40; n++) begin
            logic [7:0] op;
            op = 8'($urandom);
            if (op == 8'h00) op = 8'h03;
            setup_word = mk_setup(op, int'($urandom % 4), int'($urandom % 4), int'($urandom % 4),
                                  8'($urandom), int'($urandom % 32));
            mm_read(24'($urandom), d, cyc);
        end

        check(oe_bad_hdr == 0, "R4 only lane 0 enabled for opcode/address", 32'(oe_bad_hdr), 32'h0);
        check(oe_bad_tail == 0, "R5 no lane enabled in dummy/data", 32'(oe_bad_tail), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule